// File: doc/BRIEF.md
# Prioritized Nested Interrupt Controller

This block collects up to 60 interrupt request lines, records each one as pending, and picks among the enabled pending lines the one with the most urgent 4-bit priority. A smaller priority value is more urgent. When two lines have the same priority, the lower channel index wins. The winner is offered to the processor core through a small handshake. The controller raises a request, drives the channel number as the vector, and waits for an entry acknowledge. The core later reports the end of the handler with an exit strobe.

The controller keeps the priority level of the running handler. A new request is presented only when it is strictly more urgent than that level. Each entry pushes the interrupted level onto a 16-deep stack, and each exit pops it back.

The request and vector are combinational from the pending state, so they react at once. A more urgent line that becomes pending while the core is still entering a handler replaces the vector on offer (late arrival). In the cycle after an exit, a tail-chain flag marks a request that the core can take without first returning to the interrupted context. A per-channel register port sets the enable bits, the pending bits and the priorities, and reads them back.

Top module: `prio_nest_intc`

## Requirements
- R1: After reset, every enable bit, pending bit and priority reads 0. `cur_level` is 16, meaning no handler is running. `nest_depth` is 0, and `irq_req`, `irq_vec` and `irq_tail` are 0.
- R2: A line whose `irq_in` bit is high at a clock edge reads pending from the next cycle, whether or not it is enabled. This holds even if software clears that pending bit in the same cycle. A pending line whose enable bit is 0 never raises `irq_req`; setting its enable bit lets it be presented.
- R3: Among the pending and enabled lines, the line with the smallest priority value is offered. Equal values go to the lower channel index. `irq_vec` carries the channel index.
- R4: `irq_req` is high only when the winning priority value is strictly smaller than `cur_level`. A request of equal priority waits.
- R5: When `irq_ack` is high in a cycle with `irq_req` high, the offered channel is entered. From the next cycle its pending bit reads 0, `cur_level` equals its priority and `nest_depth` is one higher. Nesting never goes beyond 16 levels.
- R6: Until the acknowledge, the vector follows the most urgent line. A more urgent line that becomes pending during entry appears on `irq_vec` in the following cycle. The acknowledge enters the line shown in its own cycle, and the line it displaced stays pending.
- R7: An `irq_exit` pulse while `nest_depth` is non-zero restores the level that was interrupted and lowers `nest_depth` by one. An exit pulse at depth 0 changes nothing.
- R8: In the cycle after an accepted exit, `irq_tail` equals `irq_req`, marking a chained handler. In every other cycle `irq_tail` is 0.
- R9: Register access uses `reg_sel` to choose the target: 0 is the enable bit (data bit 0), 1 is the pending bit (data bit 0 written as 1 sets it, as 0 clears it), 2 is the 4-bit priority, and 3 reads 0. `reg_rdata` shows the selected field of channel `reg_idx` in the same cycle. An index of 60 or more is ignored on write and reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 60 | Request lines, one per channel |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register target select |
| reg_idx | input | 6 | Channel index for register access |
| reg_wdata | input | 4 | Register write data |
| reg_rdata | output | 4 | Register read data |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | 6 | Vector (channel index) of the offered request |
| irq_tail | output | 1 | Offered request chains directly from an exit |
| irq_ack | input | 1 | Core accepts the offered request (entry done) |
| irq_exit | input | 1 | Core leaves the current handler |
| cur_level | output | 5 | Priority level of the running handler, 16 when none runs |
| nest_depth | output | 5 | Number of nested handlers in progress |

## Verification
A table of line pairs tests arbitration across several cases: different priorities, equal priorities, the extreme channel indices, and both ends of the priority range. These cases separate value ordering from index ordering, so a swapped tie-break or a wrong comparison sense shows up. Directed sequences then nest handlers at distinct levels, offer an equal-priority line that must wait, and exit twice so that only the second exit tail-chains into it. A more urgent line is raised between request and acknowledge to show the vector switching and the displaced line staying pending. Register probes cover disabled-but-pending lines, software set and clear, a request that wins over a simultaneous clear, and out-of-range indices.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int LINES_MAX  = 64;
    localparam int LINES_DEF  = 60;
    localparam int IDX_W      = $clog2(LINES_MAX);
    localparam int PRIO_W     = 4;
    localparam int LVL_W      = PRIO_W + 1;
    localparam int NEST_DEF   = 16;
    localparam logic [LVL_W-1:0] BASE_LVL = LVL_W'(1 << PRIO_W);

    typedef enum logic [1:0] {
        SEL_ENABLE = 2'd0,
        SEL_PEND   = 2'd1,
        SEL_PRIO   = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              valid;
        logic [PRIO_W-1:0] prio;
        logic [IDX_W-1:0]  idx;
    } cand_t;

    // lo covers lower channel indices: it wins ties
    function automatic cand_t pick(input cand_t lo, input cand_t hi);
        if (lo.valid && (!hi.valid || lo.prio <= hi.prio))
            return lo;
        return hi;
    endfunction

endpackage

// File: rtl/intc_regfile.sv
module intc_regfile
    import intc_pkg::*;
#(
    parameter int NUM_LINES = LINES_DEF
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic                 reg_we,
    input  reg_sel_e             reg_sel,
    input  logic [IDX_W-1:0]     reg_idx,
    input  logic [PRIO_W-1:0]    reg_wdata,
    output logic [PRIO_W-1:0]    reg_rdata,
    input  logic                 ack_fire,
    input  logic [IDX_W-1:0]     ack_idx,
    output logic [NUM_LINES-1:0] en_q,
    output logic [NUM_LINES-1:0] pend_q,
    output logic [PRIO_W-1:0]    prio_q [NUM_LINES]
);

    logic idx_ok;
    assign idx_ok = 32'(reg_idx) < NUM_LINES;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_chan
        logic hit;
        assign hit = reg_we && idx_ok && (reg_idx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                en_q[g]   <= 1'b0;
                prio_q[g] <= '0;
            end else begin
                if (hit && reg_sel == SEL_ENABLE) en_q[g]   <= reg_wdata[0];
                if (hit && reg_sel == SEL_PRIO)   prio_q[g] <= reg_wdata;
            end
        end

        // precedence: request line, then software write, then entry clear
        always_ff @(posedge clk) begin
            if (rst)
                pend_q[g] <= 1'b0;
            else if (irq_in[g])
                pend_q[g] <= 1'b1;
            else if (hit && reg_sel == SEL_PEND)
                pend_q[g] <= reg_wdata[0];
            else if (ack_fire && ack_idx == IDX_W'(g))
                pend_q[g] <= 1'b0;
        end

        p_req_sets_r2: assert property (@(posedge clk) disable iff (rst)
            irq_in[g] |=> pend_q[g]);
    end

    always_comb begin
        reg_rdata = '0;
        if (idx_ok) begin
            case (reg_sel)
                SEL_ENABLE: reg_rdata = {{(PRIO_W-1){1'b0}}, en_q[reg_idx]};
                SEL_PEND:   reg_rdata = {{(PRIO_W-1){1'b0}}, pend_q[reg_idx]};
                SEL_PRIO:   reg_rdata = prio_q[reg_idx];
                default:    reg_rdata = '0;
            endcase
        end
    end

    p_ack_clears_r5: assert property (@(posedge clk) disable iff (rst)
        (ack_fire && !irq_in[ack_idx] && !(reg_we && reg_sel == SEL_PEND))
        |=> !pend_q[$past(ack_idx)]);

endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
    import intc_pkg::*;
#(
    parameter int NUM_LINES = LINES_DEF
) (
    input  logic [NUM_LINES-1:0] elig,
    input  logic [PRIO_W-1:0]    prio [NUM_LINES],
    output cand_t                win
);

    localparam int LEAVES = 1 << $clog2(NUM_LINES);
    localparam int NODES  = 2 * LEAVES - 1;

    // heap layout: node k has children 2k+1 (lower indices) and 2k+2
    cand_t node [NODES];

    for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
        if (i < NUM_LINES) begin : g_real
            assign node[LEAVES-1+i] = '{valid: elig[i], prio: prio[i], idx: IDX_W'(i)};
        end else begin : g_pad
            assign node[LEAVES-1+i] = '0;
        end
    end

    for (genvar k = 0; k < LEAVES - 1; k++) begin : g_node
        assign node[k] = pick(node[2*k+1], node[2*k+2]);
    end

    assign win = node[0];

endmodule

// File: rtl/intc_prio_stack.sv
module intc_prio_stack
    import intc_pkg::*;
#(
    parameter int DEPTH = NEST_DEF
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           push,
    input  logic [LVL_W-1:0]               push_lvl,
    input  logic                           pop,
    output logic [LVL_W-1:0]               cur_lvl,
    output logic [$clog2(DEPTH+1)-1:0]     depth
);

    localparam int SP_W = $clog2(DEPTH + 1);
    localparam int AW   = $clog2(DEPTH);

    logic [LVL_W-1:0] saved [DEPTH];
    logic [SP_W-1:0]  sp, sp_m1;

    assign sp_m1 = sp - 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            sp      <= '0;
            cur_lvl <= BASE_LVL;
        end else if (push) begin
            saved[sp[AW-1:0]] <= cur_lvl;
            sp                <= sp + 1'b1;
            cur_lvl           <= push_lvl;
        end else if (pop && sp != '0) begin
            cur_lvl <= saved[sp_m1[AW-1:0]];
            sp      <= sp_m1;
        end
    end

    assign depth = sp;

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
        push |-> (32'(sp) < DEPTH));

    p_pop_restore_r7: assert property (@(posedge clk) disable iff (rst)
        (pop && !push && sp != '0) |=> (sp == $past(sp) - 1'b1));

endmodule

// File: rtl/prio_nest_intc.sv
module prio_nest_intc
    import intc_pkg::*;
#(
    parameter int NUM_LINES = LINES_DEF,
    parameter int NEST      = NEST_DEF
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_LINES-1:0]          irq_in,
    input  logic                          reg_we,
    input  logic [1:0]                    reg_sel,
    input  logic [IDX_W-1:0]              reg_idx,
    input  logic [PRIO_W-1:0]             reg_wdata,
    output logic [PRIO_W-1:0]             reg_rdata,
    output logic                          irq_req,
    output logic [IDX_W-1:0]              irq_vec,
    output logic                          irq_tail,
    input  logic                          irq_ack,
    input  logic                          irq_exit,
    output logic [LVL_W-1:0]              cur_level,
    output logic [$clog2(NEST+1)-1:0]     nest_depth
);

    logic [NUM_LINES-1:0] en_q, pend_q, elig;
    logic [PRIO_W-1:0]    prio_q [NUM_LINES];
    cand_t                win;
    logic                 ack_ok, exit_ok, tail_q;

    intc_regfile #(.NUM_LINES(NUM_LINES)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .irq_in    (irq_in),
        .reg_we    (reg_we),
        .reg_sel   (reg_sel_e'(reg_sel)),
        .reg_idx   (reg_idx),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ack_fire  (ack_ok),
        .ack_idx   (win.idx),
        .en_q      (en_q),
        .pend_q    (pend_q),
        .prio_q    (prio_q)
    );

    assign elig = en_q & pend_q;

    intc_arbiter #(.NUM_LINES(NUM_LINES)) u_arb (
        .elig (elig),
        .prio (prio_q),
        .win  (win)
    );

    intc_prio_stack #(.DEPTH(NEST)) u_stack (
        .clk      (clk),
        .rst      (rst),
        .push     (ack_ok),
        .push_lvl ({1'b0, win.prio}),
        .pop      (exit_ok),
        .cur_lvl  (cur_level),
        .depth    (nest_depth)
    );

    // strict preemption: equal level waits
    assign irq_req = win.valid && ({1'b0, win.prio} < cur_level);
    assign irq_vec = irq_req ? win.idx : '0;
    assign ack_ok  = irq_ack && irq_req;
    assign exit_ok = irq_exit && (nest_depth != '0) && !ack_ok;

    always_ff @(posedge clk) begin
        if (rst) tail_q <= 1'b0;
        else     tail_q <= exit_ok;
    end

    assign irq_tail = tail_q && irq_req;

    p_vec_eligible_r3: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> elig[irq_vec]);

    p_enter_urgent_r4: assert property (@(posedge clk) disable iff (rst)
        ack_ok |=> (cur_level < $past(cur_level)));

    p_enter_depth_r5: assert property (@(posedge clk) disable iff (rst)
        ack_ok |=> (nest_depth == $past(nest_depth) + 1'b1));

    p_idle_exit_r7: assert property (@(posedge clk) disable iff (rst)
        (irq_exit && nest_depth == '0 && !ack_ok) |=> $stable(cur_level));

endmodule

// File: tb/prio_nest_intc_test.sv
module prio_nest_intc_test;

    localparam int CLK_PERIOD = 10;
    localparam int N = 60;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [N-1:0] irq_in = '0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [5:0]  reg_idx = '0;
    logic [3:0]  reg_wdata = '0;
    logic [3:0]  reg_rdata;
    logic        irq_req, irq_tail;
    logic [5:0]  irq_vec;
    logic        irq_ack = 1'b0, irq_exit = 1'b0;
    logic [4:0]  cur_level, nest_depth;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prio_nest_intc uut (
        .clk(clk), .rst(rst), .irq_in(irq_in),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_req(irq_req), .irq_vec(irq_vec), .irq_tail(irq_tail),
        .irq_ack(irq_ack), .irq_exit(irq_exit),
        .cur_level(cur_level), .nest_depth(nest_depth)
    );

    // {a, prio_a, b, prio_b, expected vector}
    localparam logic [25:0] ARB_TAB [6] = '{
        {6'd3,  4'd5,  6'd9,  4'd2,  6'd9},
        {6'd12, 4'd1,  6'd40, 4'd7,  6'd12},
        {6'd33, 4'd6,  6'd17, 4'd6,  6'd17},
        {6'd0,  4'd15, 6'd59, 4'd14, 6'd59},
        {6'd59, 4'd0,  6'd1,  4'd0,  6'd1},
        {6'd44, 4'd0,  6'd45, 4'd15, 6'd44}
    };

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int sel, input int idx, input int d);
        reg_we = 1'b1; reg_sel = 2'(sel); reg_idx = 6'(idx); reg_wdata = 4'(d);
        step();
        reg_we = 1'b0;
    endtask

    task automatic rd(input int sel, input int idx, output int v);
        reg_sel = 2'(sel); reg_idx = 6'(idx);
        #1;
        v = int'(reg_rdata);
    endtask

    task automatic pulse(input int ch);
        irq_in[ch] = 1'b1;
        step();
        irq_in = '0;
    endtask

    task automatic do_ack();
        irq_ack = 1'b1; step(); irq_ack = 1'b0; #1;
    endtask

    task automatic do_exit();
        irq_exit = 1'b1; step(); irq_exit = 1'b0; #1;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got 0 expected 1 (run ended)");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int v;
        repeat (3) step();
        rst = 1'b0;
        step();

        // R1 reset state
        chk("R1 irq_req", irq_req, 0);
        chk("R1 irq_vec", irq_vec, 0);
        chk("R1 irq_tail", irq_tail, 0);
        chk("R1 cur_level", cur_level, 16);
        chk("R1 nest_depth", nest_depth, 0);
        rd(0, 7, v); chk("R1 enable", v, 0);
        rd(1, 7, v); chk("R1 pending", v, 0);
        rd(2, 7, v); chk("R1 priority", v, 0);

        // R3 arbitration table
        for (int e = 0; e < 6; e++) begin
            int a, pa, b, pb, ex;
            a  = int'(ARB_TAB[e][25:20]);
            pa = int'(ARB_TAB[e][19:16]);
            b  = int'(ARB_TAB[e][15:10]);
            pb = int'(ARB_TAB[e][9:6]);
            ex = int'(ARB_TAB[e][5:0]);
            wr(2, a, pa); wr(2, b, pb);
            wr(0, a, 1);  wr(0, b, 1);
            irq_in[a] = 1'b1; irq_in[b] = 1'b1;
            step();
            irq_in = '0;
            #1;
            chk("R3 table req", irq_req, 1);
            chk("R3 table vec", irq_vec, ex);
            wr(1, a, 0); wr(1, b, 0);
            wr(0, a, 0); wr(0, b, 0);
            chk("R3 table cleanup", irq_req, 0);
        end

        // R2 disabled line records pending but is not presented
        wr(2, 5, 4);
        pulse(5);
        rd(1, 5, v); chk("R2 pending while disabled", v, 1);
        chk("R2 no request while disabled", irq_req, 0);
        wr(0, 5, 1);
        chk("R2 request after enable", irq_req, 1);
        chk("R2 vector after enable", irq_vec, 5);

        // R5 entry
        do_ack();
        chk("R5 level after entry", cur_level, 4);
        chk("R5 depth after entry", nest_depth, 1);
        rd(1, 5, v); chk("R5 pending cleared", v, 0);
        chk("R5 no request after entry", irq_req, 0);

        // R4 equal priority waits, strictly higher preempts
        wr(2, 7, 4); wr(0, 7, 1); pulse(7);
        chk("R4 equal priority waits", irq_req, 0);
        wr(2, 8, 3); wr(0, 8, 1); pulse(8);
        chk("R4 higher preempts req", irq_req, 1);
        chk("R4 higher preempts vec", irq_vec, 8);
        do_ack();
        chk("R5 nested level", cur_level, 3);
        chk("R5 nested depth", nest_depth, 2);
        chk("R4 level 4 waits under 3", irq_req, 0);

        // R7 / R8 exit and tail chaining
        do_exit();
        chk("R7 restored level", cur_level, 4);
        chk("R7 depth after exit", nest_depth, 1);
        chk("R8 no chain when equal", irq_tail, 0);
        chk("R4 still waiting", irq_req, 0);
        do_exit();
        chk("R7 base level", cur_level, 16);
        chk("R7 depth zero", nest_depth, 0);
        chk("R8 chained req", irq_req, 1);
        chk("R8 chained vec", irq_vec, 7);
        chk("R8 tail flag", irq_tail, 1);
        step();
        chk("R8 tail flag one cycle", irq_tail, 0);
        chk("R8 request held", irq_req, 1);
        do_ack();
        chk("R5 enter chained", cur_level, 4);
        do_exit();
        chk("R8 no tail without request", irq_tail, 0);
        do_exit();
        chk("R7 idle exit level", cur_level, 16);
        chk("R7 idle exit depth", nest_depth, 0);

        // R6 late arrival during entry
        wr(2, 20, 9); wr(0, 20, 1); pulse(20);
        chk("R6 first vector", irq_vec, 20);
        wr(2, 30, 2); wr(0, 30, 1);
        chk("R6 still first", irq_vec, 20);
        pulse(30);
        chk("R6 switched vector", irq_vec, 30);
        do_ack();
        chk("R6 entered late one", cur_level, 2);
        rd(1, 30, v); chk("R6 late one cleared", v, 0);
        rd(1, 20, v); chk("R6 displaced still pending", v, 1);
        do_exit();
        chk("R8 chain to displaced", irq_tail, 1);
        chk("R8 chain vec", irq_vec, 20);
        do_ack();
        do_exit();
        chk("R7 clean exit", nest_depth, 0);

        // R9 register interface
        rd(2, 30, v); chk("R9 priority readback", v, 2);
        wr(2, 60, 7);
        rd(2, 60, v); chk("R9 out of range reads 0", v, 0);
        rd(3, 5, v);  chk("R9 select 3 reads 0", v, 0);
        rd(0, 5, v);  chk("R9 enable readback", v, 1);
        wr(1, 20, 1);
        rd(1, 20, v); chk("R9 software set", v, 1);
        chk("R9 software set presents", irq_vec, 20);
        wr(1, 20, 0);
        chk("R9 software clear", irq_req, 0);

        // R2 request wins over simultaneous software clear
        irq_in[20] = 1'b1;
        wr(1, 20, 0);
        irq_in = '0;
        rd(1, 20, v); chk("R2 request beats clear", v, 1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule